// File: doc/BRIEF.md
# PCI bridge configuration register file

This block holds the configuration registers of a PCI-to-PCI bridge that sit above the common header: bus numbers, the secondary latency timer, the I/O, memory and prefetchable windows with their upper extensions, the expansion ROM address, and the interrupt and bridge control dword. It accepts 32-bit configuration reads and writes addressed by a byte offset whose two low bits are ignored. Every write replaces the whole dword, because no byte enables exist.

Accesses below offset 0x18 belong to the common header. The block passes them straight through to a separate header port and returns that port's read data. Each instance gets its writable bits from parameters. The masks for the windows and the latency timer decide which bits a write may change. The low nibble of each window mask is the read-only type code, and it selects 16-bit or 32-bit I/O addressing and 32-bit or 64-bit prefetchable addressing. The upper-extension registers accept data only when that type code selects wide addressing.

Top module: `bridge_cfg_regs`

## Requirements
- R1: An access with offset below 0x18 drives hdrWrEn/hdrRdEn, hdrOffset and hdrWrData from the request unchanged, returns hdrRdData on cfgRdData, and changes no local register. An access at or above 0x18 never raises hdrWrEn or hdrRdEn.
- R2: Dword 0x18 reads primary bus in bits 7:0, secondary bus in 15:8, subordinate bus in 23:16 and secondary latency timer in 31:24. A write stores all three bus numbers as given.
- R3: A write to dword 0x18 changes only the latency-timer bits set in LAT_MASK and keeps all other latency-timer bits.
- R4: Dword 0x1C reads I/O base in 7:0, I/O limit in 15:8 and the constant SEC_STATUS in 31:16. Writes to bits 31:16 are ignored.
- R5: Writing an I/O base/limit (0x1C), memory base/limit (0x20, base 15:0, limit 31:16) or prefetchable base/limit (0x24, same split) stores the value ANDed with its mask (IO_MASK, MEM_MASK, PREF_MASK) in bits above 3, with bits 3:0 set to bits 3:0 of the mask.
- R6: Dword 0x30 holds the I/O upper-16 base in 15:0 and limit in 31:16. A write updates each half only if the stored low nibble of the I/O base (for 15:0) or I/O limit (for 31:16) equals 1.
- R7: Dwords 0x28 and 0x2C (prefetchable upper-32 base and limit) take a write only when PREF_MASK[3:0] equals 1, and otherwise keep their value.
- R8: Dword 0x3C reads bridge control in 31:16, the constant INT_PIN in 15:8 and the interrupt line in 7:0. A write stores bits 31:16 and 7:0.
- R9: A read at an unimplemented offset at or above 0x18 (0x34, 0x40 to 0xFC) returns zero, and a write there changes nothing.
- R10: A write takes effect at the clock edge that samples cfgWrEn high. cfgRdData is combinational, so a read in the same cycle as a write to the same dword returns the old contents.
- R11: After reset every writable field reads zero, including the window type nibbles.
- R12: Dword 0x38 (expansion ROM address) stores the written value ANDed with ROM_MASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe, forwarded for header offsets |
| cfgOffset | input | 8 | Byte offset of the dword, bits 1:0 ignored |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, combinational |
| hdrWrEn | output | 1 | Write strobe to the common header |
| hdrRdEn | output | 1 | Read strobe to the common header |
| hdrOffset | output | 8 | Offset passed to the common header |
| hdrWrData | output | 32 | Write data passed to the common header |
| hdrRdData | input | 32 | Read data from the common header |

## Verification
A read and a write to the same dword can occur in the same cycle, because the offset port is shared and read data is combinational. The bench holds a write strobe on one dword, samples cfgRdData before the clock edge and expects the old value, then samples it after the edge and expects the new one. A second pairing inside one access is the dword 0x30 write together with the type nibble it depends on. That case is provoked before and after the first I/O window write, and on an instance whose masks select narrow addressing, where the upper registers must stay zero.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 8;
  localparam int IDX_W  = OFS_W - 2;

  // dword indices (offset >> 2)
  localparam logic [IDX_W-1:0] IDX_HDR_END = 6'h06;
  localparam logic [IDX_W-1:0] IDX_BUS     = 6'h06;
  localparam logic [IDX_W-1:0] IDX_IO      = 6'h07;
  localparam logic [IDX_W-1:0] IDX_MEM     = 6'h08;
  localparam logic [IDX_W-1:0] IDX_PREF    = 6'h09;
  localparam logic [IDX_W-1:0] IDX_PBU     = 6'h0A;
  localparam logic [IDX_W-1:0] IDX_PLU     = 6'h0B;
  localparam logic [IDX_W-1:0] IDX_IOU     = 6'h0C;
  localparam logic [IDX_W-1:0] IDX_ROM     = 6'h0E;
  localparam logic [IDX_W-1:0] IDX_INTR    = 6'h0F;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BUS, SEL_IO, SEL_MEM, SEL_PREF,
    SEL_PBU, SEL_PLU, SEL_IOU, SEL_ROM, SEL_INTR
  } rdSel_e;

  typedef struct packed {
    logic wrBus;
    logic wrIo;
    logic wrMem;
    logic wrPref;
    logic wrPbu;
    logic wrPlu;
    logic wrIou;
    logic wrRom;
    logic wrIntr;
  } wrStrb_t;

  function automatic logic [15:0] maskWin16(input logic [15:0] val, input logic [15:0] mask);
    return (val & mask & 16'hFFF0) | {12'h000, mask[3:0]};
  endfunction

  function automatic logic [7:0] maskWin8(input logic [7:0] val, input logic [7:0] mask);
    return (val & mask & 8'hF0) | {4'h0, mask[3:0]};
  endfunction
endpackage

// File: rtl/bridge_cfg_ctrl.sv
module bridge_cfg_ctrl
  import bridge_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] dwIdx,
  output wrStrb_t          strb,
  output rdSel_e           rdSel,
  output logic             localHit,
  output logic             hdrWrEn,
  output logic             hdrRdEn
);
  logic localWr;

  always_comb begin
    localHit = (dwIdx >= IDX_HDR_END);
    hdrWrEn  = wrEn & ~localHit;
    hdrRdEn  = rdEn & ~localHit;
    localWr  = wrEn & localHit;
    unique case (dwIdx)
      IDX_BUS:  rdSel = SEL_BUS;
      IDX_IO:   rdSel = SEL_IO;
      IDX_MEM:  rdSel = SEL_MEM;
      IDX_PREF: rdSel = SEL_PREF;
      IDX_PBU:  rdSel = SEL_PBU;
      IDX_PLU:  rdSel = SEL_PLU;
      IDX_IOU:  rdSel = SEL_IOU;
      IDX_ROM:  rdSel = SEL_ROM;
      IDX_INTR: rdSel = SEL_INTR;
      default:  rdSel = SEL_NONE;
    endcase
    strb.wrBus  = localWr & (rdSel == SEL_BUS);
    strb.wrIo   = localWr & (rdSel == SEL_IO);
    strb.wrMem  = localWr & (rdSel == SEL_MEM);
    strb.wrPref = localWr & (rdSel == SEL_PREF);
    strb.wrPbu  = localWr & (rdSel == SEL_PBU);
    strb.wrPlu  = localWr & (rdSel == SEL_PLU);
    strb.wrIou  = localWr & (rdSel == SEL_IOU);
    strb.wrRom  = localWr & (rdSel == SEL_ROM);
    strb.wrIntr = localWr & (rdSel == SEL_INTR);
  end

  AST_HDR_NO_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    hdrWrEn |-> (strb == '0)); // R1
  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R9
  AST_HOLE_NO_STRB: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && dwIdx == 6'h0D) |-> (strb == '0)); // R9
endmodule

// File: rtl/bridge_cfg_data.sv
module bridge_cfg_data
  import bridge_cfg_pkg::*;
#(
  parameter logic [7:0]  LAT_MASK   = 8'hF8,
  parameter logic [7:0]  IO_MASK    = 8'hF1,
  parameter logic [15:0] MEM_MASK   = 16'hFFF0,
  parameter logic [15:0] PREF_MASK  = 16'hFFF1,
  parameter logic [31:0] ROM_MASK   = 32'hFFFF_F801,
  parameter logic [15:0] SEC_STATUS = 16'h0280,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrb_t           strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam bit PREF_WIDE = (PREF_MASK[3:0] == 4'h1);

  logic [7:0]  priBus, secBus, subBus, secLat;
  logic [7:0]  ioBase, ioLimit;
  logic [15:0] memBase, memLimit, prefBase, prefLimit;
  logic [15:0] ioBaseUp, ioLimUp;
  logic [31:0] prefBaseUp, prefLimUp;
  logic [31:0] romAddr;
  logic [15:0] bridgeCtl;
  logic [7:0]  intLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priBus <= '0; secBus <= '0; subBus <= '0; secLat <= '0;
      ioBase <= '0; ioLimit <= '0;
      memBase <= '0; memLimit <= '0; prefBase <= '0; prefLimit <= '0;
      ioBaseUp <= '0; ioLimUp <= '0;
      romAddr <= '0; bridgeCtl <= '0; intLine <= '0;
    end else begin
      if (strb.wrBus) begin
        priBus <= wrData[7:0];
        secBus <= wrData[15:8];
        subBus <= wrData[23:16];
        secLat <= (secLat & ~LAT_MASK) | (wrData[31:24] & LAT_MASK);
      end
      if (strb.wrIo) begin
        ioBase  <= maskWin8(wrData[7:0], IO_MASK);
        ioLimit <= maskWin8(wrData[15:8], IO_MASK);
      end
      if (strb.wrMem) begin
        memBase  <= maskWin16(wrData[15:0], MEM_MASK);
        memLimit <= maskWin16(wrData[31:16], MEM_MASK);
      end
      if (strb.wrPref) begin
        prefBase  <= maskWin16(wrData[15:0], PREF_MASK);
        prefLimit <= maskWin16(wrData[31:16], PREF_MASK);
      end
      if (strb.wrIou) begin
        if (ioBase[3:0] == 4'h1)  ioBaseUp <= wrData[15:0];
        if (ioLimit[3:0] == 4'h1) ioLimUp  <= wrData[31:16];
      end
      if (strb.wrRom) romAddr <= wrData & ROM_MASK;
      if (strb.wrIntr) begin
        bridgeCtl <= wrData[31:16];
        intLine   <= wrData[7:0];
      end
    end
  end

  // Upper prefetchable halves exist as writable storage only for wide mode.
  generate
    if (PREF_WIDE) begin : g_prefWide
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prefBaseUp <= '0;
          prefLimUp  <= '0;
        end else begin
          if (strb.wrPbu) prefBaseUp <= wrData;
          if (strb.wrPlu) prefLimUp  <= wrData;
        end
      end
      AST_PBU_TAKE: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrPbu |=> prefBaseUp == $past(wrData)); // R7
    end else begin : g_prefNarrow
      assign prefBaseUp = '0;
      assign prefLimUp  = '0;
    end
  endgenerate

  always_comb begin
    unique case (rdSel)
      SEL_BUS:  rdData = {secLat, subBus, secBus, priBus};
      SEL_IO:   rdData = {SEC_STATUS, ioLimit, ioBase};
      SEL_MEM:  rdData = {memLimit, memBase};
      SEL_PREF: rdData = {prefLimit, prefBase};
      SEL_PBU:  rdData = prefBaseUp;
      SEL_PLU:  rdData = prefLimUp;
      SEL_IOU:  rdData = {ioLimUp, ioBaseUp};
      SEL_ROM:  rdData = romAddr;
      SEL_INTR: rdData = {bridgeCtl, INT_PIN, intLine};
      default:  rdData = '0;
    endcase
  end

  logic [263:0] snap;
  assign snap = {priBus, secBus, subBus, secLat, ioBase, ioLimit,
                 memBase, memLimit, prefBase, prefLimit, ioBaseUp, ioLimUp,
                 prefBaseUp, prefLimUp, romAddr, bridgeCtl, intLine};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(snap)); // R10
  AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBus |=> ((secLat & ~LAT_MASK) == ($past(secLat) & ~LAT_MASK))); // R3
  AST_IO_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIo |=> (ioBase[3:0] == IO_MASK[3:0] && ioLimit[3:0] == IO_MASK[3:0])); // R5
  AST_MEM_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMem |=> (memBase[3:0] == MEM_MASK[3:0])); // R5
  AST_IOU_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIou && ioBase[3:0] != 4'h1) |=> $stable(ioBaseUp)); // R6
  AST_IOU_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIou && ioLimit[3:0] == 4'h1) |=> ioLimUp == $past(wrData[31:16])); // R6
  AST_PBU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!PREF_WIDE && strb.wrPbu) |=> $stable(prefBaseUp)); // R7
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bridge_cfg_pkg::*;
#(
  parameter logic [7:0]  LAT_MASK   = 8'hF8,
  parameter logic [7:0]  IO_MASK    = 8'hF1,
  parameter logic [15:0] MEM_MASK   = 16'hFFF0,
  parameter logic [15:0] PREF_MASK  = 16'hFFF1,
  parameter logic [31:0] ROM_MASK   = 32'hFFFF_F801,
  parameter logic [15:0] SEC_STATUS = 16'h0280,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [7:0]  cfgOffset,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        hdrWrEn,
  output logic        hdrRdEn,
  output logic [7:0]  hdrOffset,
  output logic [31:0] hdrWrData,
  input  logic [31:0] hdrRdData
);
  wrStrb_t           strb;
  rdSel_e            rdSel;
  logic              localHit;
  logic [DATA_W-1:0] localRd;

  bridge_cfg_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (cfgWrEn),
    .rdEn     (cfgRdEn),
    .dwIdx    (cfgOffset[OFS_W-1:2]),
    .strb     (strb),
    .rdSel    (rdSel),
    .localHit (localHit),
    .hdrWrEn  (hdrWrEn),
    .hdrRdEn  (hdrRdEn)
  );

  bridge_cfg_data #(
    .LAT_MASK   (LAT_MASK),
    .IO_MASK    (IO_MASK),
    .MEM_MASK   (MEM_MASK),
    .PREF_MASK  (PREF_MASK),
    .ROM_MASK   (ROM_MASK),
    .SEC_STATUS (SEC_STATUS),
    .INT_PIN    (INT_PIN)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (cfgWrData),
    .rdData (localRd)
  );

  assign hdrOffset = cfgOffset;
  assign hdrWrData = cfgWrData;
  assign cfgRdData = localHit ? localRd : hdrRdData;

  AST_HIGH_NO_HDR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset >= 8'h18) |-> !(hdrWrEn || hdrRdEn)); // R1
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset < 8'h18) |-> (cfgRdData == hdrRdData)); // R1
endmodule

// File: tb/bridge_cfg_regs_test.sv
`timescale 1ns/1ps
module bridge_cfg_regs_test;
  localparam logic [7:0]  W_LAT = 8'hF8,  N_LAT = 8'hFF;
  localparam logic [7:0]  W_IO  = 8'hF1,  N_IO  = 8'hF0;
  localparam logic [15:0] W_MEM = 16'hFFF0, N_MEM = 16'hFF00;
  localparam logic [15:0] W_PRF = 16'hFFF1, N_PRF = 16'hFFF0;
  localparam logic [31:0] W_ROM = 32'hFFFF_F801, N_ROM = 32'hFFFF_0001;
  localparam logic [15:0] STS   = 16'h0280;
  localparam logic [7:0]  PIN   = 8'h01;
  localparam logic [31:0] HDR_VAL = 32'hA5A5_0F0F;

  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0, cfgRdEn = 0;
  logic [7:0] cfgOffset = 8'h18;
  logic [31:0] cfgWrData = '0;
  logic [31:0] rdW, rdN, hdrWrDataW, hdrWrDataN;
  logic hdrWrEnW, hdrRdEnW, hdrWrEnN, hdrRdEnN;
  logic [7:0] hdrOffsetW, hdrOffsetN;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  bridge_cfg_regs uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgOffset(cfgOffset), .cfgWrData(cfgWrData), .cfgRdData(rdW),
    .hdrWrEn(hdrWrEnW), .hdrRdEn(hdrRdEnW), .hdrOffset(hdrOffsetW),
    .hdrWrData(hdrWrDataW), .hdrRdData(HDR_VAL));

  bridge_cfg_regs #(.LAT_MASK(N_LAT), .IO_MASK(N_IO), .MEM_MASK(N_MEM),
    .PREF_MASK(N_PRF), .ROM_MASK(N_ROM), .SEC_STATUS(STS), .INT_PIN(PIN)) uutNarrow (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgOffset(cfgOffset), .cfgWrData(cfgWrData), .cfgRdData(rdN),
    .hdrWrEn(hdrWrEnN), .hdrRdEn(hdrRdEnN), .hdrOffset(hdrOffsetN),
    .hdrWrData(hdrWrDataN), .hdrRdData(HDR_VAL));

  function automatic logic [7:0] win8(input logic [7:0] v, input logic [7:0] m);
    return (v & m & 8'hF0) | {4'h0, m[3:0]};
  endfunction
  function automatic logic [15:0] win16(input logic [15:0] v, input logic [15:0] m);
    return (v & m & 16'hFFF0) | {12'h0, m[3:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] o, input logic [31:0] d);
    @(negedge clk);
    cfgOffset = o; cfgWrData = d; cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] o);
    cfgOffset = o;
    #1;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog R10 act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
    $finish;
  end

  initial begin
    logic [7:0] latW, latN;
    logic [31:0] d, expW, expN;
    logic [31:0] snapW [16];
    logic [31:0] snapN [16];
    latW = 0; latN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R11: reset values of every local dword
    for (int o = 8'h18; o <= 8'h3C; o += 4) begin
      expW = (o == 8'h1C) ? {STS, 16'h0} : (o == 8'h3C) ? {16'h0, PIN, 8'h00} : 32'h0;
      rd(o[7:0]);
      chk($sformatf("R11 reset off=%h", o), rdW, expW);
      chk($sformatf("R11 reset narrow off=%h", o), rdN, expW);
    end

    // R1: header pass-through
    @(negedge clk);
    cfgOffset = 8'h10; cfgWrData = 32'hDEAD_BEEF; cfgWrEn = 1; cfgRdEn = 1;
    #1;
    chk("R1 hdrWrEn low offset", {31'h0, hdrWrEnW}, 32'h1);
    chk("R1 hdrRdEn low offset", {31'h0, hdrRdEnW}, 32'h1);
    chk("R1 hdrOffset", {24'h0, hdrOffsetW}, 32'h10);
    chk("R1 hdrWrData", hdrWrDataW, 32'hDEAD_BEEF);
    chk("R1 read returns header data", rdW, HDR_VAL);
    @(negedge clk);
    cfgOffset = 8'h18; cfgWrEn = 0;
    #1;
    chk("R1 hdrRdEn high offset", {31'h0, hdrRdEnW}, 32'h0);
    chk("R1 local untouched by header write", rdW, 32'h0);
    cfgRdEn = 0;

    // R2 / R3: bus number sweep
    for (int i = 0; i < 24; i++) begin
      d = (i * 32'h1357_9BDF) ^ 32'hA5C3_6E01;
      wr(8'h18, d);
      latW = (latW & ~W_LAT) | (d[31:24] & W_LAT);
      latN = (latN & ~N_LAT) | (d[31:24] & N_LAT);
      rd(8'h18);
      chk($sformatf("R2 R3 bus dword i=%0d", i), rdW, {latW, d[23:0]});
      chk($sformatf("R3 narrow lat i=%0d", i), rdN, {latN, d[23:0]});
    end

    // R6: upper I/O before type nibble is set
    wr(8'h30, 32'h1234_5678);
    rd(8'h30);
    chk("R6 io upper blocked before window write", rdW, 32'h0);

    // R4 / R5: I/O window sweep
    for (int i = 0; i < 32; i++) begin
      d = {16'hFFFF, 8'(i * 8'h37 + 8'h0B), 8'(i * 8'h1D)};
      wr(8'h1C, d);
      rd(8'h1C);
      chk($sformatf("R4 R5 io i=%0d", i), rdW, {STS, win8(d[15:8], W_IO), win8(d[7:0], W_IO)});
      chk($sformatf("R5 io narrow i=%0d", i), rdN, {STS, win8(d[15:8], N_IO), win8(d[7:0], N_IO)});
    end

    // R6: upper I/O after nibble = 1 (wide) / 0 (narrow)
    wr(8'h30, 32'h1234_5678);
    rd(8'h30);
    chk("R6 io upper taken", rdW, 32'h1234_5678);
    chk("R6 io upper narrow blocked", rdN, 32'h0);

    // R5: memory and prefetchable sweeps
    for (int i = 0; i < 32; i++) begin
      d = (i * 32'h0F1E_2D3C) ^ 32'h5A5A_A5A5;
      wr(8'h20, d);
      rd(8'h20);
      chk($sformatf("R5 mem i=%0d", i), rdW, {win16(d[31:16], W_MEM), win16(d[15:0], W_MEM)});
      chk($sformatf("R5 mem narrow i=%0d", i), rdN, {win16(d[31:16], N_MEM), win16(d[15:0], N_MEM)});
      wr(8'h24, ~d);
      rd(8'h24);
      chk($sformatf("R5 pref i=%0d", i), rdW, {win16(~d[31:16], W_PRF), win16(~d[15:0], W_PRF)});
      chk($sformatf("R5 pref narrow i=%0d", i), rdN, {win16(~d[31:16], N_PRF), win16(~d[15:0], N_PRF)});
    end

    // R7: prefetchable upper halves
    wr(8'h28, 32'h0000_0ABC);
    wr(8'h2C, 32'h0000_0DEF);
    rd(8'h28);
    chk("R7 pref upper base wide", rdW, 32'h0000_0ABC);
    chk("R7 pref upper base narrow", rdN, 32'h0);
    rd(8'h2C);
    chk("R7 pref upper limit wide", rdW, 32'h0000_0DEF);
    chk("R7 pref upper limit narrow", rdN, 32'h0);

    // R12: expansion ROM
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38);
    chk("R12 rom all ones", rdW, W_ROM);
    chk("R12 rom all ones narrow", rdN, N_ROM);
    wr(8'h38, 32'h1234_5FFE);
    rd(8'h38);
    chk("R12 rom pattern", rdW, 32'h1234_5FFE & W_ROM);

    // R8: interrupt / bridge control
    wr(8'h3C, 32'hBEEF_7733);
    rd(8'h3C);
    chk("R8 intr dword", rdW, {16'hBEEF, PIN, 8'h33});

    // R9: unimplemented offsets
    for (int k = 0; k < 10; k++) begin
      rd(8'(8'h18 + 4 * k));
      snapW[k] = rdW; snapN[k] = rdN;
    end
    rd(8'h34);
    chk("R9 read 0x34", rdW, 32'h0);
    rd(8'h40);
    chk("R9 read 0x40", rdW, 32'h0);
    rd(8'hFC);
    chk("R9 read 0xFC", rdW, 32'h0);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h0000_0000);
    for (int k = 0; k < 10; k++) begin
      rd(8'(8'h18 + 4 * k));
      chk($sformatf("R9 no effect k=%0d", k), rdW, snapW[k]);
      chk($sformatf("R9 no effect narrow k=%0d", k), rdN, snapN[k]);
    end

    // R10: read and write on the same dword in one cycle
    @(negedge clk);
    cfgOffset = 8'h3C; cfgWrData = 32'h0101_0055; cfgWrEn = 1;
    #1;
    chk("R10 same-cycle read is old", rdW, {16'hBEEF, PIN, 8'h33});
    @(posedge clk);
    #1;
    chk("R10 after edge is new", rdW, {16'h0101, PIN, 8'h55});
    @(negedge clk);
    cfgWrEn = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule